// File: doc/BRIEF.md
# Daisy-Chain SPI Target Frame Engine

This block is the serial target logic of one device in a chain of identical devices that share a single SPI controller. Each device's data output feeds the next device's data input. The controller sends one shared frame through the whole chain. The frame holds two header bytes, then one address slot and one data slot for every device. No device has a select line of its own: every device finds its own slots from the traffic it receives.

The device always sends its own fault status byte first. After that it forwards every byte it receives one byte later. It counts the bytes that arrive ahead of the first header byte, and that count gives its position in the chain. It reads the chain length from the first header byte. From these two values it takes its own address byte and data byte. In the slot where its address byte would have gone out, it sends a report byte: the current contents of the addressed register. Any write is committed, and any global clear-fault request is acted on, only when the select line is released.

The pins are sampled in the system clock domain through synchronizers, so SCLK must run several times slower than the system clock. The register file itself is outside the block, behind a simple read and write port.

Top module: `dc_spi_target`

## Requirements
- R1: After reset, `spiDout`, `regWrEn` and `clearFault` are 0.
- R2: Data is shifted MSB first. `spiDin` is sampled on SCLK rising edges and `spiDout` changes only after SCLK falling edges. The first byte out after `spiSel_n` falls is the status byte {2'b11, faultStatus[5:0]}.
- R3: Received byte k (counted from 0) leaves on `spiDout` unchanged as output byte k+1, except in the report slot of R5. Both header bytes are forwarded, including the five low bits of the second header byte.
- R4: A header byte has bits [7:6] = 2'b10. The first header byte received carries the chain length N in bits [5:0]. The device's position is p = (number of bytes received before that header byte) + 1. The next byte is the second header byte.
- R5: When both header bytes are valid, 1 <= N and p <= N, received byte N+1 is the device's address byte. Its bit [6] set means read-only, and bits [5:0] are the register address. Output byte N+2 is then `regRdData` at that address, in place of the forwarded address byte.
- R6: Received byte 2N+1 is the device's data byte. When `spiSel_n` rises, a write is committed if the frame held exactly 2N+2 whole bytes and the address byte has bit [6] = 0. The write is a one-cycle `regWrEn` pulse, with `regAddr` and `regWrData` holding the captured address and data.
- R7: A frame that is one byte too long, one byte too short, or ends with a partial byte commits no write.
- R8: If the second header byte is valid and its bit [5] is 1, `clearFault` pulses for one cycle after `spiSel_n` rises. This happens whatever the position, the length or the address of the frame.
- R9: If the position is out of range (p > N, or N = 0), no header byte arrives, or the second header byte lacks the 2'b10 mark, the device only forwards: no report, no write. A bad second header byte also gives no clear.
- R10: `spiDout` is 0 while the device is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiClk | input | 1 | Serial clock from the controller or the previous device |
| spiSel_n | input | 1 | Active-low chip select, shared by the whole chain |
| spiDin | input | 1 | Serial data in |
| spiDout | output | 1 | Serial data out to the next device or the controller |
| faultStatus | input | 6 | Fault flags sent in the status byte |
| regAddr | output | 6 | Register address for the report read and the write |
| regRdData | input | 8 | Register contents at `regAddr` (combinational read) |
| regWrData | output | 8 | Captured data byte |
| regWrEn | output | 1 | One-cycle write strobe |
| clearFault | output | 1 | One-cycle global clear-fault strobe |

## Verification
The hardest case to reach is a device that sits deep in a long chain. There it has to count dozens of upstream status bytes, place its address slot far from its header, and swap in the report within the half SCLK period that follows. The bench acts as the upstream part of the chain. It builds the exact byte stream such a device would receive, status-marked bytes ahead of the headers included, for positions 1 to 40 and chain lengths 0 to 63. It then predicts each output byte from the one-byte-delay rule. Frames of the wrong length, partial frames and malformed headers are built the same way, so each invalid case can be placed exactly at its boundary.

// File: rtl/dc_spi_pkg.sv
package dc_spi_pkg;
  // Frame format constants (fixed by the chain protocol)
  localparam int BYTE_W   = 8;
  localparam int LEN_W    = 6;                       // chain length field
  localparam int MAX_DEV  = (1 << LEN_W) - 1;
  localparam int CNT_W    = $clog2(2 * MAX_DEV + 3) + 1; // byte counter, saturating
  localparam int ADDR_W   = 6;
  localparam int STAT_W   = 6;
  localparam int READ_BIT = 6;                       // address byte: read-only flag
  localparam int CLR_BIT  = 5;                       // second header: clear faults
  localparam logic [1:0] HDR_MARK  = 2'b10;
  localparam logic [1:0] STAT_MARK = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxShift;      // sample spiDin into the receive shifter
    logic rxDone;       // a whole byte has arrived
    logic txLoadStatus; // select fell: load the status byte
    logic txLoadNext;   // byte boundary on the output side
    logic txShiftOut;   // ordinary output bit advance
    logic useReport;    // the next output byte is the report
    logic capAddr;      // capture own address byte
    logic capData;      // capture own data byte
  } dpStrobe_t;
endpackage

// File: rtl/dc_spi_pin_sync.sv
module dc_spi_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinNow,
  output logic [W-1:0] pinPrev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
      pinPrev <= RST_VAL;
    end else begin
      chain[0] <= pinIn;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      pinPrev <= chain[STAGES-1];
    end
  end

  assign pinNow = chain[STAGES-1];
endmodule

// File: rtl/dc_spi_ctrl.sv
module dc_spi_ctrl
  import dc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              csFall,
  input  logic              csRise,
  input  logic              csActive,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrRead,
  output dpStrobe_t         strobe,
  output logic              regWrEn,
  output logic              clearFault
);
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             hdr1Seen;
  logic [CNT_W-1:0] hdr1Idx;
  logic [LEN_W-1:0] chainLen;
  logic             hdr2Ok;
  logic             clearReq;
  logic             addrGot;
  logic             dataGot;
  logic             loadPend;
  logic             reportPend;

  logic [CNT_W-1:0] lenExt;
  logic [CNT_W-1:0] ownAddrIdx;
  logic [CNT_W-1:0] ownDataIdx;
  logic [CNT_W-1:0] frameLen;
  logic             bitEdge;
  logic             byteDone;
  logic             posOk;
  logic             isAddr;
  logic             isData;
  logic             frameOk;
  logic             isHdr;

  // Slot positions derived from the chain length
  always_comb begin
    lenExt     = {{(CNT_W-LEN_W){1'b0}}, chainLen};
    ownAddrIdx = lenExt + CNT_W'(1);
    ownDataIdx = (lenExt << 1) + CNT_W'(1);
    frameLen   = (lenExt << 1) + CNT_W'(2);
  end

  always_comb begin
    bitEdge  = sclkRise & csActive;
    byteDone = bitEdge & (bitCnt == 3'd7);
    isHdr    = (rxByte[BYTE_W-1 -: 2] == HDR_MARK);
    posOk    = hdr1Seen & hdr2Ok & (chainLen != '0) & (hdr1Idx < lenExt);
    isAddr   = byteDone & posOk & (byteCnt == ownAddrIdx);
    isData   = byteDone & posOk & (byteCnt == ownDataIdx);
    frameOk  = posOk & addrGot & dataGot & (byteCnt == frameLen) & (bitCnt == 3'd0);
  end

  // Strobes to the datapath
  always_comb begin
    strobe              = '0;
    strobe.rxShift      = bitEdge;
    strobe.rxDone       = byteDone;
    strobe.txLoadStatus = csFall;
    strobe.txLoadNext   = sclkFall & csActive & loadPend;
    strobe.txShiftOut   = sclkFall & csActive & ~loadPend;
    strobe.useReport    = reportPend;
    strobe.capAddr      = isAddr;
    strobe.capData      = isData;
  end

  // Frame tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt     <= '0;
      byteCnt    <= '0;
      hdr1Seen   <= 1'b0;
      hdr1Idx    <= '0;
      chainLen   <= '0;
      hdr2Ok     <= 1'b0;
      clearReq   <= 1'b0;
      addrGot    <= 1'b0;
      dataGot    <= 1'b0;
      loadPend   <= 1'b0;
      reportPend <= 1'b0;
    end else if (csFall) begin
      bitCnt     <= '0;
      byteCnt    <= '0;
      hdr1Seen   <= 1'b0;
      hdr1Idx    <= '0;
      chainLen   <= '0;
      hdr2Ok     <= 1'b0;
      clearReq   <= 1'b0;
      addrGot    <= 1'b0;
      dataGot    <= 1'b0;
      loadPend   <= 1'b0;
      reportPend <= 1'b0;
    end else if (bitEdge) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        if (byteCnt != '1) byteCnt <= byteCnt + CNT_W'(1);
        loadPend   <= 1'b1;
        reportPend <= isAddr;
        if (isAddr) addrGot <= 1'b1;
        if (isData) dataGot <= 1'b1;
        if (!hdr1Seen) begin
          if (isHdr) begin
            hdr1Seen <= 1'b1;
            hdr1Idx  <= byteCnt;
            chainLen <= rxByte[LEN_W-1:0];
          end
        end else if (byteCnt == hdr1Idx + CNT_W'(1)) begin
          hdr2Ok   <= isHdr;
          clearReq <= isHdr & rxByte[CLR_BIT];
        end
      end
    end else if (sclkFall && csActive && loadPend) begin
      loadPend   <= 1'b0;
      reportPend <= 1'b0;
    end
  end

  // Commit on deselect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regWrEn    <= 1'b0;
      clearFault <= 1'b0;
    end else begin
      regWrEn    <= csRise & frameOk & ~addrRead;
      clearFault <= csRise & hdr1Seen & hdr2Ok & clearReq;
    end
  end
endmodule

// File: rtl/dc_spi_dpath.sv
module dc_spi_dpath
  import dc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic              sdiBit,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrRead,
  output logic [BYTE_W-1:0] dataOut
);
  logic [BYTE_W-2:0] rxSh;
  logic [BYTE_W-1:0] rxHold;
  logic [BYTE_W-1:0] txSh;
  logic [READ_BIT:0] addrReg;

  assign rxByte = {rxSh, sdiBit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh    <= '0;
      rxHold  <= '0;
      addrReg <= '0;
      dataOut <= '0;
    end else begin
      if (strobe.rxShift) rxSh    <= rxByte[BYTE_W-2:0];
      if (strobe.rxDone)  rxHold  <= rxByte;
      if (strobe.capAddr) addrReg <= rxByte[READ_BIT:0];
      if (strobe.capData) dataOut <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSh <= '0;
    end else if (strobe.txLoadStatus) begin
      txSh <= {STAT_MARK, statusIn};
    end else if (strobe.txLoadNext) begin
      txSh <= strobe.useReport ? regRdData : rxHold;
    end else if (strobe.txShiftOut) begin
      txSh <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  assign txMsb    = txSh[BYTE_W-1];
  assign addrOut  = addrReg[ADDR_W-1:0];
  assign addrRead = addrReg[READ_BIT];
endmodule

// File: rtl/dc_spi_target.sv
module dc_spi_target
  import dc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiClk,
  input  logic              spiSel_n,
  input  logic              spiDin,
  output logic              spiDout,
  input  logic [STAT_W-1:0] faultStatus,
  output logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              clearFault
);
  logic [2:0] pinNow;
  logic [2:0] pinPrev;
  logic sclkRise, sclkFall, csFall, csRise, csActive, sdiBit;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb;
  logic addrRead;
  dpStrobe_t strobe;

  // bit 0 = SCLK, bit 1 = select (idle high), bit 2 = data in
  dc_spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pinIn({spiDin, spiSel_n, spiClk}),
    .pinNow(pinNow), .pinPrev(pinPrev)
  );

  assign sclkRise = pinNow[0] & ~pinPrev[0];
  assign sclkFall = ~pinNow[0] & pinPrev[0];
  assign csFall   = ~pinNow[1] & pinPrev[1];
  assign csRise   = pinNow[1] & ~pinPrev[1];
  assign csActive = ~pinNow[1];
  assign sdiBit   = pinNow[2];

  dc_spi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csFall(csFall), .csRise(csRise), .csActive(csActive),
    .rxByte(rxByte), .addrRead(addrRead),
    .strobe(strobe), .regWrEn(regWrEn), .clearFault(clearFault)
  );

  dc_spi_dpath u_dpath (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .sdiBit(sdiBit),
    .statusIn(faultStatus), .regRdData(regRdData),
    .rxByte(rxByte), .txMsb(txMsb),
    .addrOut(regAddr), .addrRead(addrRead), .dataOut(regWrData)
  );

  assign spiDout = csActive & txMsb;
endmodule

// File: rtl/dc_spi_target_chk.sv
module dc_spi_target_chk (
  input logic clk,
  input logic rst_n,
  input logic csActive,
  input logic csFall,
  input logic sclkFall,
  input logic spiDout,
  input logic regWrEn,
  input logic clearFault
);
  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> !regWrEn);

  p_wr_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> !csActive);

  p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearFault |=> !clearFault);

  p_clr_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clearFault |-> !csActive);

  p_dout_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csActive && $past(csActive) && !$past(sclkFall) && !$past(csFall)) |-> $stable(spiDout));
endmodule

bind dc_spi_target dc_spi_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csActive(csActive), .csFall(csFall),
  .sclkFall(sclkFall), .spiDout(spiDout), .regWrEn(regWrEn),
  .clearFault(clearFault)
);

// File: tb/dc_spi_target_test.sv
module dc_spi_target_test;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spiClk = 1'b0;
  logic       spiSel_n = 1'b1;
  logic       spiDin = 1'b0;
  logic [5:0] faultStatus = 6'h00;
  logic       spiDout;
  logic [5:0] regAddr;
  logic [7:0] regRdData;
  logic [7:0] regWrData;
  logic       regWrEn;
  logic       clearFault;

  always #5 clk = ~clk;

  dc_spi_target uut (
    .clk(clk), .rst_n(rst_n), .spiClk(spiClk), .spiSel_n(spiSel_n),
    .spiDin(spiDin), .spiDout(spiDout), .faultStatus(faultStatus),
    .regAddr(regAddr), .regRdData(regRdData), .regWrData(regWrData),
    .regWrEn(regWrEn), .clearFault(clearFault)
  );

  // Register file model
  logic [7:0] regMem [64];
  assign regRdData = regMem[regAddr];
  int wrCount = 0;
  int clrCount = 0;
  logic [5:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  always @(posedge clk) begin
    if (regWrEn) begin
      regMem[regAddr] <= regWrData;
      wrCount++;
      lastWrAddr <= regAddr;
      lastWrData <= regWrData;
    end
    if (clearFault) clrCount++;
  end

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] inBuf  [256];
  logic [7:0] outBuf [256];
  logic [7:0] expBuf [256];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spiFrame(int nBytes, int extraBits);
    spiSel_n = 1'b0;
    tick(2 * HP);
    for (int b = 0; b < nBytes; b++) begin
      logic [7:0] r;
      r = '0;
      for (int k = 7; k >= 0; k--) begin
        spiDin = inBuf[b][k];
        tick(HP);
        r[k] = spiDout;
        spiClk = 1'b1;
        tick(HP);
        spiClk = 1'b0;
      end
      outBuf[b] = r;
    end
    for (int k = 0; k < extraBits; k++) begin
      spiDin = 1'b1;
      tick(HP);
      spiClk = 1'b1;
      tick(HP);
      spiClk = 1'b0;
    end
    tick(HP);
    spiSel_n = 1'b1;
    tick(3 * HP);
  endtask

  // Stream seen by a device at position pos in a chain of n
  task automatic buildFrame(int pos, int n, logic [7:0] h2, logic [7:0] addr,
                            logic [7:0] data, bit place);
    int len;
    len = 2 * n + 2;
    for (int i = 0; i < len; i++) inBuf[i] = {2'b01, 6'(i)};
    for (int i = 0; i < pos - 1; i++) inBuf[i] = {2'b11, 6'(i + 7)};
    inBuf[pos-1] = {2'b10, 6'(n)};
    inBuf[pos]   = h2;
    if (place) begin
      inBuf[n+1]     = addr;
      inBuf[2*n + 1] = data;
    end
  endtask

  task automatic expFrame(int len, logic [5:0] stat, bit rep, int repIdx, logic [7:0] repVal);
    expBuf[0] = {2'b11, stat};
    for (int j = 1; j < len; j++) expBuf[j] = inBuf[j-1];
    if (rep) expBuf[repIdx] = repVal;
  endtask

  task automatic cmpFrame(string req, int len);
    for (int j = 0; j < len; j++) chk(req, $sformatf("out byte %0d", j), outBuf[j], expBuf[j]);
  endtask

  task automatic testReset();
    chk("R1", "spiDout after reset", spiDout, 0);
    chk("R1", "regWrEn after reset", regWrEn, 0);
    chk("R1", "clearFault after reset", clearFault, 0);
    chk("R10", "spiDout idle", spiDout, 0);
  endtask

  task automatic testWriteFirst();
    int w0, c0;
    w0 = wrCount; c0 = clrCount;
    faultStatus = 6'h2B;
    regMem[5] = 8'hA7;
    buildFrame(1, 1, 8'h80, 8'h05, 8'h3C, 1);
    expFrame(4, 6'h2B, 1, 3, 8'hA7);
    spiFrame(4, 0);
    chk("R2", "status byte", outBuf[0], 8'hEB);
    chk("R3", "header 1 forwarded", outBuf[1], 8'h81);
    chk("R5", "report of old contents", outBuf[3], 8'hA7);
    cmpFrame("R3", 4);
    chk("R6", "write count", wrCount - w0, 1);
    chk("R6", "write addr", lastWrAddr, 5);
    chk("R6", "write data", lastWrData, 8'h3C);
    chk("R6", "register updated", regMem[5], 8'h3C);
    chk("R8", "no clear", clrCount - c0, 0);
    chk("R10", "spiDout after frame", spiDout, 0);
  endtask

  task automatic testReadMiddleClear();
    int w0, c0;
    w0 = wrCount; c0 = clrCount;
    faultStatus = 6'h11;
    regMem[17] = 8'h6E;
    buildFrame(2, 3, 8'hB5, 8'h51, 8'h99, 1);
    expFrame(8, 6'h11, 1, 5, 8'h6E);
    spiFrame(8, 0);
    chk("R4", "header 2 low bits forwarded", outBuf[3], 8'hB5);
    chk("R5", "report at slot N+2", outBuf[5], 8'h6E);
    cmpFrame("R5", 8);
    chk("R5", "read-only frame no write", wrCount - w0, 0);
    chk("R8", "clear pulse", clrCount - c0, 1);
  endtask

  task automatic testWriteLast();
    int w0, c0;
    w0 = wrCount; c0 = clrCount;
    faultStatus = 6'h3F;
    regMem[34] = 8'h00;
    buildFrame(3, 3, 8'h9F, 8'h22, 8'hD1, 1);
    expFrame(8, 6'h3F, 1, 5, 8'h00);
    spiFrame(8, 0);
    cmpFrame("R4", 8);
    chk("R6", "last device write", wrCount - w0, 1);
    chk("R6", "last device data", regMem[34], 8'hD1);
    chk("R8", "no clear when bit clear", clrCount - c0, 0);
    // read back through a different chain shape
    buildFrame(1, 2, 8'h80, 8'h62, 8'h00, 1);
    expFrame(6, 6'h3F, 1, 4, 8'hD1);
    spiFrame(6, 0);
    cmpFrame("R5", 6);
    chk("R5", "readback report", outBuf[4], 8'hD1);
    chk("R6", "readback no write", wrCount - w0, 1);
  endtask

  task automatic testLength();
    int w0;
    w0 = wrCount;
    regMem[9] = 8'h77;
    buildFrame(1, 2, 8'h80, 8'h09, 8'h11, 1);
    inBuf[6] = 8'h55;
    expFrame(7, 6'h3F, 1, 4, 8'h77);
    spiFrame(7, 0);
    cmpFrame("R7", 7);
    chk("R7", "long frame no write", wrCount - w0, 0);
    buildFrame(1, 2, 8'h80, 8'h09, 8'h11, 1);
    spiFrame(6, 3);
    chk("R7", "partial byte no write", wrCount - w0, 0);
    buildFrame(1, 2, 8'h80, 8'h09, 8'h11, 1);
    spiFrame(5, 0);
    chk("R7", "short frame no write", wrCount - w0, 0);
    chk("R7", "register untouched", regMem[9], 8'h77);
  endtask

  task automatic testBadPosition();
    int w0, c0;
    w0 = wrCount; c0 = clrCount;
    faultStatus = 6'h05;
    buildFrame(3, 2, 8'hA0, 8'h00, 8'h00, 0);
    expFrame(6, 6'h05, 0, 0, 8'h00);
    spiFrame(6, 0);
    cmpFrame("R9", 6);
    chk("R9", "p>N no write", wrCount - w0, 0);
    chk("R8", "clear still global", clrCount - c0, 1);
    buildFrame(1, 0, 8'h80, 8'h00, 8'h00, 0);
    expFrame(2, 6'h05, 0, 0, 8'h00);
    spiFrame(2, 0);
    cmpFrame("R9", 2);
    chk("R9", "N=0 no write", wrCount - w0, 0);
  endtask

  task automatic testNoHeader();
    int w0, c0;
    w0 = wrCount; c0 = clrCount;
    for (int i = 0; i < 6; i++) inBuf[i] = (i % 2 == 0) ? 8'hC3 : 8'h3A;
    expFrame(6, 6'h05, 0, 0, 8'h00);
    spiFrame(6, 0);
    cmpFrame("R9", 6);
    chk("R9", "no header no write", wrCount - w0, 0);
    regMem[3] = 8'h12;
    buildFrame(1, 1, 8'h20, 8'h03, 8'h44, 1);
    expFrame(4, 6'h05, 0, 0, 8'h00);
    spiFrame(4, 0);
    cmpFrame("R9", 4);
    chk("R9", "bad header 2 no write", wrCount - w0, 0);
    chk("R9", "bad header 2 no clear", clrCount - c0, 0);
    chk("R9", "register untouched", regMem[3], 8'h12);
  endtask

  task automatic testLongChain();
    int w0;
    w0 = wrCount;
    faultStatus = 6'h2A;
    regMem[63] = 8'hE4;
    buildFrame(40, 63, 8'h8C, 8'h3F, 8'h5A, 1);
    expFrame(128, 6'h2A, 1, 65, 8'hE4);
    spiFrame(128, 0);
    cmpFrame("R4", 128);
    chk("R5", "deep report", outBuf[65], 8'hE4);
    chk("R6", "deep write", wrCount - w0, 1);
    chk("R6", "deep data", regMem[63], 8'h5A);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) regMem[i] = 8'(i * 3);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    testReset();
    testWriteFirst();
    testReadMiddleClear();
    testWriteLast();
    testLength();
    testBadPosition();
    testNoHeader();
    testLongChain();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule